// File: doc/BRIEF.md
# MMU Special Register Access Unit

This block holds the software-visible registers of a memory management unit and turns register-bus accesses into traffic toward an external translation table. Software selects a table entry through an index register. It then reads or writes that entry's tag word or data word through two window registers. The lowest bit of the register number picks the word.

Accessing the tag window also moves the process identifier. A tag write stamps the current identifier into the entry as its translation ID. A tag read copies the entry's translation ID back into the identifier register.

A write to the search register starts a table lookup of the page number of the written address. The bus is held off until the result returns. A hit replaces the index register with the matching entry number. A miss sets the top index bit, which software cannot write. Two configuration inputs gate every access: one gives the MMU mode and one gives the access level.

Top module: `mmu_sreg_unit`

## Requirements
- R1: After reset the index, process identifier and zone registers read as zero. `req_ready` is 1, and `err_pulse` and `rd_valid` are 0.
- R2: The two window registers are register numbers 2 and 3, and bit 0 of the register number chooses the word: 3 is the tag word and 2 is the data word. Both address the entry given by index bits [7:0]. A write drives the entry write port in the same cycle. A read returns the entry word on `rd_data` one cycle after acceptance, with `rd_valid` high.
- R3: A write to the tag window (number 3) drives `tlb_wr_tid` with bits [7:0] of the process identifier register (number 4).
- R4: A read of the tag window loads the process identifier register with the selected entry's translation ID, zero-extended.
- R5: Bit 31 of the index register (number 6) cannot be written. A write to the index register updates only bits [30:0].
- R6: A write to the search register (number 7) issues a lookup on `srch_page`, which is the written value with bits [9:0] cleared. `req_ready` stays low until the response. On a hit, the index register becomes the returned entry number, zero-extended.
- R7: On a search miss, index bit 31 is set and bits [30:0] are kept.
- R8: Reading the search register returns zero.
- R9: When `cfg_mode` is below 2 or `cfg_access` is 0, every access is ignored. No register changes, no entry write is issued, and reads return zero.
- R10: Writes to the identifier register (4), the zone register (5) and the search register need `cfg_access` of 2 or more. Reads of the windows, the identifier register and the zone register need `cfg_access` bit 0 set. A refused access changes nothing and reads as zero.
- R11: An access to any undefined register number (anything outside 2 to 7) is ignored and reads as zero. When the unit is enabled, it raises `err_pulse` for exactly the one cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_mode | input | 2 | MMU mode; below 2 means no MMU registers |
| cfg_access | input | 2 | Register access level |
| req_valid | input | 1 | Bus access request |
| req_ready | output | 1 | Unit can accept an access (low during search) |
| req_write | input | 1 | 1 for write, 0 for read |
| req_rnum | input | 4 | Register number |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after a read is accepted |
| rd_data | output | 32 | Read data |
| err_pulse | output | 1 | One-cycle flag for an undefined register number |
| tlb_wr_en | output | 1 | Entry write strobe |
| tlb_wr_tag | output | 1 | 1 writes the tag word, 0 the data word |
| tlb_wr_idx | output | 8 | Entry number written |
| tlb_wr_data | output | 32 | Word written |
| tlb_wr_tid | output | 8 | Translation ID stored with a tag write |
| tlb_rd_idx | output | 8 | Entry number read |
| tlb_rd_tag | input | 32 | Tag word of the read entry |
| tlb_rd_data | input | 32 | Data word of the read entry |
| tlb_rd_tid | input | 8 | Translation ID of the read entry |
| srch_req | output | 1 | Lookup request, held until response |
| srch_page | output | 32 | Page address searched |
| srch_rsp_valid | input | 1 | Lookup response strobe |
| srch_rsp_hit | input | 1 | Lookup found an entry |
| srch_rsp_idx | input | 8 | Matching entry number |

## Verification
The hardest state to reach is index bit 31 set. Software can never write that bit, so the only way to set it is a search that misses. The bench fills the tag of one entry through the window and then searches an address whose page is absent from its table model. That produces the miss. It then writes the index again to show the bit survives, and it checks the refused and disabled configurations against that sticky value.

// File: rtl/mmu_sreg_pkg.sv
// Package: register numbers and decoded access class shared by the unit.
// Assumes a 4-bit register number on the bus.
package mmu_sreg_pkg;
    localparam int RN_W = 4;

    typedef enum logic [RN_W-1:0] {
        RN_WIN_DATA = 4'h2,
        RN_WIN_TAG  = 4'h3,
        RN_PID      = 4'h4,
        RN_ZONE     = 4'h5,
        RN_INDEX    = 4'h6,
        RN_SEARCH   = 4'h7
    } rnum_e;

    typedef struct packed {
        logic win;
        logic tag;
        logic pid;
        logic zone;
        logic index;
        logic search;
        logic undef;
        logic allow;
    } dec_t;
endpackage

// File: rtl/mmu_sreg_decode.sv
// Module: decodes the register number and applies the access-level gating.
// Assumes cfg inputs are static during an access; purely combinational.
module mmu_sreg_decode
    import mmu_sreg_pkg::*;
(
    input  logic [RN_W-1:0] rnum,
    input  logic            write,
    input  logic [1:0]      cfg_mode,
    input  logic [1:0]      cfg_access,
    output dec_t            dec,
    output logic            enabled
);
    logic priv_wr;
    logic rd_ok;

    // Classify the register number and decide whether the access is allowed.
    always_comb begin
        dec      = '0;
        enabled  = (cfg_mode >= 2'd2) && (cfg_access != 2'd0);
        priv_wr  = (cfg_access >= 2'd2);
        rd_ok    = cfg_access[0];
        case (rnum_e'(rnum))
            RN_WIN_DATA, RN_WIN_TAG: dec.win = 1'b1;
            RN_PID:                  dec.pid = 1'b1;
            RN_ZONE:                 dec.zone = 1'b1;
            RN_INDEX:                dec.index = 1'b1;
            RN_SEARCH:               dec.search = 1'b1;
            default:                 dec.undef = 1'b1;
        endcase
        dec.tag = dec.win & rnum[0];
        if (write)
            dec.allow = enabled & ((dec.win | dec.index) |
                                   ((dec.pid | dec.zone | dec.search) & priv_wr));
        else
            dec.allow = enabled & ((dec.index | dec.search) |
                                   ((dec.win | dec.pid | dec.zone) & rd_ok));
    end
endmodule

// File: rtl/mmu_sreg_search.sv
// Module: tracks one outstanding table search from start to response.
// Assumes the responder answers once per request; request is held until then.
module mmu_sreg_search #(
    parameter int DATA_W   = 32,
    parameter int IDX_W    = 8,
    parameter int PAGE_LSB = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] vaddr,
    output logic              srch_req,
    output logic [DATA_W-1:0] srch_page,
    input  logic              srch_rsp_valid,
    input  logic              srch_rsp_hit,
    input  logic [IDX_W-1:0]  srch_rsp_idx,
    output logic              busy,
    output logic              done,
    output logic              done_hit,
    output logic [IDX_W-1:0]  done_idx
);
    localparam logic [DATA_W-1:0] PAGE_MASK =
        {{(DATA_W-PAGE_LSB){1'b1}}, {PAGE_LSB{1'b0}}};

    logic              busy_q;
    logic [DATA_W-1:0] page_q;

    // Hold the searched page and the busy flag until the response arrives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            page_q <= '0;
        end else if (busy_q && srch_rsp_valid) begin
            busy_q <= 1'b0;
        end else if (start && !busy_q) begin
            busy_q <= 1'b1;
            page_q <= vaddr & PAGE_MASK;
        end
    end

    assign srch_req  = busy_q;
    assign srch_page = page_q;
    assign busy      = busy_q;
    assign done      = busy_q & srch_rsp_valid;
    assign done_hit  = srch_rsp_hit;
    assign done_idx  = srch_rsp_idx;
endmodule

// File: rtl/mmu_sreg_unit.sv
// Module: MMU special register unit. Holds index, identifier and zone registers,
// gives windowed access to table entries and runs searches.
// Assumes a combinational table read port and one access per accepted cycle.
module mmu_sreg_unit
    import mmu_sreg_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int IDX_W    = 8,
    parameter int TID_W    = 8,
    parameter int PAGE_LSB = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_mode,
    input  logic [1:0]        cfg_access,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [RN_W-1:0]   req_rnum,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              err_pulse,
    output logic              tlb_wr_en,
    output logic              tlb_wr_tag,
    output logic [IDX_W-1:0]  tlb_wr_idx,
    output logic [DATA_W-1:0] tlb_wr_data,
    output logic [TID_W-1:0]  tlb_wr_tid,
    output logic [IDX_W-1:0]  tlb_rd_idx,
    input  logic [DATA_W-1:0] tlb_rd_tag,
    input  logic [DATA_W-1:0] tlb_rd_data,
    input  logic [TID_W-1:0]  tlb_rd_tid,
    output logic              srch_req,
    output logic [DATA_W-1:0] srch_page,
    input  logic              srch_rsp_valid,
    input  logic              srch_rsp_hit,
    input  logic [IDX_W-1:0]  srch_rsp_idx
);
    localparam int TOP = DATA_W - 1;

    dec_t              dec;
    logic              enabled;
    logic              accept, go, wr_go, rd_go;
    logic              busy, done, done_hit;
    logic [IDX_W-1:0]  done_idx;
    logic [DATA_W-1:0] index_q, pid_q, zone_q, rd_next;

    mmu_sreg_decode u_dec (
        .rnum       (req_rnum),
        .write      (req_write),
        .cfg_mode   (cfg_mode),
        .cfg_access (cfg_access),
        .dec        (dec),
        .enabled    (enabled)
    );

    mmu_sreg_search #(
        .DATA_W   (DATA_W),
        .IDX_W    (IDX_W),
        .PAGE_LSB (PAGE_LSB)
    ) u_srch (
        .clk            (clk),
        .rst_n          (rst_n),
        .start          (wr_go & dec.search),
        .vaddr          (req_wdata),
        .srch_req       (srch_req),
        .srch_page      (srch_page),
        .srch_rsp_valid (srch_rsp_valid),
        .srch_rsp_hit   (srch_rsp_hit),
        .srch_rsp_idx   (srch_rsp_idx),
        .busy           (busy),
        .done           (done),
        .done_hit       (done_hit),
        .done_idx       (done_idx)
    );

    // Bus handshake: stall while a search is outstanding.
    assign req_ready = ~busy;
    assign accept    = req_valid & req_ready;
    assign go        = accept & dec.allow;
    assign wr_go     = go & req_write;
    assign rd_go     = go & ~req_write;

    // Entry ports addressed by the index register.
    assign tlb_wr_en   = wr_go & dec.win;
    assign tlb_wr_tag  = dec.tag;
    assign tlb_wr_idx  = index_q[IDX_W-1:0];
    assign tlb_wr_data = req_wdata;
    assign tlb_wr_tid  = pid_q[TID_W-1:0];
    assign tlb_rd_idx  = index_q[IDX_W-1:0];

    // Select read data; refused or unknown reads give zero.
    always_comb begin
        rd_next = '0;
        if (rd_go) begin
            if (dec.win)        rd_next = dec.tag ? tlb_rd_tag : tlb_rd_data;
            else if (dec.pid)   rd_next = pid_q;
            else if (dec.zone)  rd_next = zone_q;
            else if (dec.index) rd_next = index_q;
        end
    end

    // Index register: search result first, else software write of low bits.
    always_ff @(posedge clk) begin
        if (!rst_n)
            index_q <= '0;
        else if (done)
            index_q <= done_hit ? {{(DATA_W-IDX_W){1'b0}}, done_idx}
                                : {1'b1, index_q[TOP-1:0]};
        else if (wr_go && dec.index)
            index_q <= {index_q[TOP], req_wdata[TOP-1:0]};
    end

    // Identifier register: software write, or load from entry on tag read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pid_q <= '0;
        else if (wr_go && dec.pid)
            pid_q <= req_wdata;
        else if (rd_go && dec.tag)
            pid_q <= {{(DATA_W-TID_W){1'b0}}, tlb_rd_tid};
    end

    // Zone register: plain software write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            zone_q <= '0;
        else if (wr_go && dec.zone)
            zone_q <= req_wdata;
    end

    // Registered read response and undefined-number error pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid  <= 1'b0;
            rd_data   <= '0;
            err_pulse <= 1'b0;
        end else begin
            rd_valid  <= accept & ~req_write;
            rd_data   <= rd_next;
            err_pulse <= accept & dec.undef & enabled;
        end
    end
endmodule

// File: rtl/mmu_sreg_checker.sv
// Checker: temporal properties of the register unit, bound to every instance.
module mmu_sreg_checker
    import mmu_sreg_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        cfg_mode,
    input logic [1:0]        cfg_access,
    input logic              req_valid,
    input logic              req_ready,
    input logic              req_write,
    input logic [RN_W-1:0]   req_rnum,
    input logic              rd_valid,
    input logic [DATA_W-1:0] rd_data,
    input logic              err_pulse,
    input logic              tlb_wr_en,
    input logic              srch_req,
    input logic              srch_rsp_valid,
    input logic              srch_rsp_hit,
    input logic [IDX_W-1:0]  srch_rsp_idx,
    input logic [DATA_W-1:0] index_q
);
    logic en_cfg, rn_undef, acc;
    assign en_cfg   = (cfg_mode >= 2'd2) && (cfg_access != 2'd0);
    assign rn_undef = (req_rnum < 4'h2) || (req_rnum > 4'h7);
    assign acc      = req_valid && req_ready;

    p_search_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        srch_req |-> !req_ready);
    p_search_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (srch_req && srch_rsp_valid && srch_rsp_hit) |=>
        index_q == {{(DATA_W-IDX_W){1'b0}}, $past(srch_rsp_idx)});
    p_search_miss_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (srch_req && srch_rsp_valid && !srch_rsp_hit) |=>
        index_q == {1'b1, $past(index_q[DATA_W-2:0])});
    p_bit31_ro_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && req_write && req_rnum == RN_INDEX) |=>
        index_q[DATA_W-1] == $past(index_q[DATA_W-1]));
    p_search_reads_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !req_write && req_rnum == RN_SEARCH) |=> rd_data == '0);
    p_disabled_no_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tlb_wr_en |-> en_cfg);
    p_disabled_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !en_cfg) |=> rd_data == '0);
    p_err_source_r11: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> ($past(acc) && $past(rn_undef)));
    p_read_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(acc && !req_write));
endmodule

bind mmu_sreg_unit mmu_sreg_checker #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_access(cfg_access),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_rnum(req_rnum), .rd_valid(rd_valid), .rd_data(rd_data),
    .err_pulse(err_pulse), .tlb_wr_en(tlb_wr_en), .srch_req(srch_req),
    .srch_rsp_valid(srch_rsp_valid), .srch_rsp_hit(srch_rsp_hit),
    .srch_rsp_idx(srch_rsp_idx), .index_q(index_q)
);

// File: tb/test_mmu_sreg_unit.sv
module test_mmu_sreg_unit;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] PMASK = 32'hFFFF_FC00;

    typedef struct packed {
        logic        wr;
        logic [3:0]  rn;
        logic [31:0] wd;
        logic [31:0] exp;
        logic [7:0]  req;
    } vec_t;

    // Table walk at full access: R2 windows, R3/R4 identifier swap, R5, R8, R10.
    localparam vec_t VECS [13] = '{
        '{1'b1, 4'h6, 32'h0000_0005, 32'h0,          8'd5},
        '{1'b1, 4'h4, 32'h0000_0012, 32'h0,          8'd3},
        '{1'b1, 4'h3, 32'h0000_4C40, 32'h0,          8'd2},
        '{1'b1, 4'h2, 32'hABCD_0000, 32'h0,          8'd2},
        '{1'b0, 4'h2, 32'h0,         32'hABCD_0000,  8'd2},
        '{1'b1, 4'h4, 32'h0,         32'h0,          8'd10},
        '{1'b0, 4'h3, 32'h0,         32'h0000_4C40,  8'd2},
        '{1'b0, 4'h4, 32'h0,         32'h0000_0012,  8'd4},
        '{1'b1, 4'h6, 32'hFFFF_FF07, 32'h0,          8'd5},
        '{1'b0, 4'h6, 32'h0,         32'h7FFF_FF07,  8'd5},
        '{1'b1, 4'h5, 32'hC000_0003, 32'h0,          8'd10},
        '{1'b0, 4'h5, 32'h0,         32'hC000_0003,  8'd10},
        '{1'b0, 4'h7, 32'h0,         32'h0,          8'd8}
    };

    logic        clk = 1'b0, rst_n = 1'b0;
    logic [1:0]  cfg_mode = 2'd2, cfg_access = 2'd3;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [3:0]  req_rnum = '0;
    logic [31:0] req_wdata = '0;
    logic        req_ready, rd_valid, err_pulse;
    logic [31:0] rd_data;
    logic        tlb_wr_en, tlb_wr_tag;
    logic [7:0]  tlb_wr_idx, tlb_wr_tid, tlb_rd_idx, tlb_rd_tid;
    logic [31:0] tlb_wr_data, tlb_rd_tag, tlb_rd_data;
    logic        srch_req, srch_rsp_valid, srch_rsp_hit;
    logic [31:0] srch_page;
    logic [7:0]  srch_rsp_idx;

    logic [31:0] tag_mem [256];
    logic [31:0] data_mem [256];
    logic [7:0]  tid_mem [256];
    logic        used [256];
    logic [1:0]  rsp_cnt;

    int checks = 0, fails = 0;
    logic [31:0] rdv;
    logic        errv;

    always #(CLK_PERIOD/2) clk = ~clk;

    mmu_sreg_unit i_mmu_sreg_unit (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_access(cfg_access),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_rnum(req_rnum), .req_wdata(req_wdata), .rd_valid(rd_valid),
        .rd_data(rd_data), .err_pulse(err_pulse), .tlb_wr_en(tlb_wr_en),
        .tlb_wr_tag(tlb_wr_tag), .tlb_wr_idx(tlb_wr_idx), .tlb_wr_data(tlb_wr_data),
        .tlb_wr_tid(tlb_wr_tid), .tlb_rd_idx(tlb_rd_idx), .tlb_rd_tag(tlb_rd_tag),
        .tlb_rd_data(tlb_rd_data), .tlb_rd_tid(tlb_rd_tid), .srch_req(srch_req),
        .srch_page(srch_page), .srch_rsp_valid(srch_rsp_valid),
        .srch_rsp_hit(srch_rsp_hit), .srch_rsp_idx(srch_rsp_idx)
    );

    assign tlb_rd_tag  = tag_mem[tlb_rd_idx];
    assign tlb_rd_data = data_mem[tlb_rd_idx];
    assign tlb_rd_tid  = tid_mem[tlb_rd_idx];

    function automatic logic [8:0] lookup(input logic [31:0] page);
        for (int i = 0; i < 256; i++)
            if (used[i] && ((tag_mem[i] & PMASK) == page)) return {1'b1, 8'(i)};
        return 9'd0;
    endfunction

    // Table model and search responder (answers on the third request cycle).
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) begin
                tag_mem[i] <= '0; data_mem[i] <= '0; tid_mem[i] <= '0; used[i] <= 1'b0;
            end
            srch_rsp_valid <= 1'b0; srch_rsp_hit <= 1'b0; srch_rsp_idx <= '0; rsp_cnt <= '0;
        end else begin
            if (tlb_wr_en) begin
                if (tlb_wr_tag) begin
                    tag_mem[tlb_wr_idx] <= tlb_wr_data;
                    tid_mem[tlb_wr_idx] <= tlb_wr_tid;
                    used[tlb_wr_idx]    <= 1'b1;
                end else begin
                    data_mem[tlb_wr_idx] <= tlb_wr_data;
                end
            end
            if (srch_rsp_valid) srch_rsp_valid <= 1'b0;
            else if (srch_req) begin
                if (rsp_cnt == 2'd2) begin
                    srch_rsp_valid <= 1'b1;
                    {srch_rsp_hit, srch_rsp_idx} <= lookup(srch_page);
                    rsp_cnt <= '0;
                end else rsp_cnt <= rsp_cnt + 2'd1;
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic acc(input logic wr, input logic [3:0] rn, input logic [31:0] wd,
                       output logic [31:0] rd, output logic er);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_rnum = rn; req_wdata = wd;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        #1;
        req_valid = 1'b0;
        rd = rd_data; er = err_pulse;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        do_reset();
        // R1: idle outputs after reset
        @(negedge clk);
        check("R1 ready", {31'd0, req_ready}, 32'd1);
        check("R1 err", {31'd0, err_pulse}, 32'd0);
        check("R1 rd_valid", {31'd0, rd_valid}, 32'd0);

        for (int v = 0; v < 13; v++) begin
            acc(VECS[v].wr, VECS[v].rn, VECS[v].wd, rdv, errv);
            if (!VECS[v].wr) check($sformatf("R%0d vec%0d", VECS[v].req, v), rdv, VECS[v].exp);
        end

        // R3: tag write carried identifier; R2: words landed in entry 5
        check("R3 tid", {24'd0, tid_mem[5]}, 32'h12);
        check("R2 tag", tag_mem[5], 32'h0000_4C40);
        check("R2 data", data_mem[5], 32'hABCD_0000);

        // R6: search hit, stall and page
        acc(1'b1, 4'h7, 32'h0000_4C7F, rdv, errv);
        check("R6 stall", {31'd0, req_ready}, 32'd0);
        check("R6 page", srch_page, 32'h0000_4C00);
        acc(1'b0, 4'h6, 32'h0, rdv, errv);
        check("R6 hit index", rdv, 32'h0000_0005);

        // R7: miss sets bit 31; R5: bit survives a write
        acc(1'b1, 4'h6, 32'h9, rdv, errv);
        acc(1'b1, 4'h7, 32'h9000_0000, rdv, errv);
        acc(1'b0, 4'h6, 32'h0, rdv, errv);
        check("R7 miss index", rdv, 32'h8000_0009);
        acc(1'b1, 4'h6, 32'h3, rdv, errv);
        acc(1'b0, 4'h6, 32'h0, rdv, errv);
        check("R5 sticky bit31", rdv, 32'h8000_0003);

        // R10: access level 1 refuses privileged writes
        cfg_access = 2'd1;
        acc(1'b1, 4'h4, 32'h55, rdv, errv);
        acc(1'b0, 4'h4, 32'h0, rdv, errv);
        check("R10 pid write refused", rdv, 32'h12);
        acc(1'b1, 4'h7, 32'h0000_4C00, rdv, errv);
        check("R10 search refused ready", {31'd0, req_ready}, 32'd1);
        acc(1'b0, 4'h6, 32'h0, rdv, errv);
        check("R10 search refused index", rdv, 32'h8000_0003);
        acc(1'b1, 4'h5, 32'h0, rdv, errv);
        acc(1'b0, 4'h5, 32'h0, rdv, errv);
        check("R10 zone write refused", rdv, 32'hC000_0003);

        // R10: access level 2 refuses reads needing bit 0
        cfg_access = 2'd2;
        acc(1'b0, 4'h4, 32'h0, rdv, errv);
        check("R10 pid read refused", rdv, 32'h0);
        acc(1'b0, 4'h6, 32'h0, rdv, errv);
        check("R10 index readable", rdv, 32'h8000_0003);

        // R9: disabled mode ignores everything
        cfg_access = 2'd3; cfg_mode = 2'd1;
        acc(1'b1, 4'h6, 32'h22, rdv, errv);
        acc(1'b1, 4'h3, 32'h1234, rdv, errv);
        acc(1'b0, 4'h6, 32'h0, rdv, errv);
        check("R9 read zero", rdv, 32'h0);
        check("R9 no entry write", tag_mem[3], 32'h0);
        cfg_mode = 2'd2;
        acc(1'b0, 4'h6, 32'h0, rdv, errv);
        check("R9 index kept", rdv, 32'h8000_0003);

        // R11: undefined register number
        acc(1'b0, 4'hF, 32'h0, rdv, errv);
        check("R11 read zero", rdv, 32'h0);
        check("R11 err high", {31'd0, errv}, 32'd1);
        @(posedge clk); #1;
        check("R11 err one cycle", {31'd0, err_pulse}, 32'd0);

        // R1: registers cleared by a later reset
        do_reset();
        acc(1'b0, 4'h6, 32'h0, rdv, errv);
        check("R1 index", rdv, 32'h0);
        acc(1'b0, 4'h4, 32'h0, rdv, errv);
        check("R1 pid", rdv, 32'h0);
        acc(1'b0, 4'h5, 32'h0, rdv, errv);
        check("R1 zone", rdv, 32'h0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule